// File: doc/BRIEF.md
# Rotating Priority Interrupt Arbiter

This block keeps eight interrupt lines' request, mask and in-service bits. Each cycle it decides whether the interrupt output should be raised and which line wins. Each line's request bit is captured in one of two ways, chosen per line by `trig_level`:
- Edge mode sets the bit on a rising input.
- Level mode makes the bit track the input.

Priority is measured from a 3-bit rotating base. A pending line raises the output only if its level is strictly better than that of every line counted as in service. Two static mode inputs change which in-service bits are counted. `sm_en` drops masked in-service lines from the comparison. `sfn_en` drops the cascade line on a master unit.

An acknowledge pulse moves the current winner into service. For an edge-mode winner it also clears the request bit. Single-cycle operation codes end service and move the base:
- end of service for the best in-service line, with or without rotation;
- end of service for a named line, with or without rotation;
- setting the base directly.

All state is synchronous. The decision is evaluated on the next-state values, so `irq_out` and `win_line` always agree with the state outputs shown in the same cycle. The bus register interface, vector generation and cascading are handled by neighbouring logic.

Top module: `prio_irq_arbiter`

## Requirements
- R1: A synchronous reset clears request, in-service, mask and base to zero and holds `irq_out` low.
- R2: Line i has level (i - base) mod 8, where level 0 is best. The winner is the unmasked pending line with the best level. `win_line` is 0 when nothing is pending.
- R3: `irq_out` is 1 exactly when the best pending level is strictly better than the best counted in-service level. An empty in-service set counts as level 8.
- R4: In edge mode (`trig_level[i]`=0) a request bit is set only when the input rises from its last sampled value. An acknowledge (`ack`=1 while `irq_out`=1) sets the in-service bit of `win_line` and clears that line's edge request.
- R5: In level mode (`trig_level[i]`=1) a request bit equals the input sampled at the previous edge. An acknowledge does not clear it.
- R6: With `sm_en`=1, in-service lines that are masked are left out of the comparison.
- R7: With `sfn_en`=1 on a master unit, the in-service bit of the cascade line (line 2 by default) is left out of the comparison.
- R8: `op_code` 1 clears the best-priority in-service bit. `op_code` 2 does the same and also sets the base to that line + 1 mod 8. When nothing is in service, both change nothing.
- R9: `op_code` 3 clears the in-service bit of `op_line`. `op_code` 4 clears it and sets the base to `op_line` + 1. `op_code` 5 sets the base to `op_line` + 1 and leaves the in-service bits unchanged. `op_code` 0 does nothing.
- R10: `mask_we`=1 loads `mask_wdata` into the mask. A masked request stays in the request bits but cannot raise `irq_out`.
- R11: `ack` while `irq_out`=0 changes nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_in | input | 8 | Interrupt request inputs |
| trig_level | input | 8 | Per-line capture mode, 1 = level, 0 = edge |
| mask_we | input | 1 | Mask load strobe |
| mask_wdata | input | 8 | New mask value |
| sm_en | input | 1 | Special mask mode enable |
| sfn_en | input | 1 | Special fully nested mode enable |
| ack | input | 1 | Acknowledge of the current winner |
| op_code | input | 3 | Service/rotation command, one cycle |
| op_line | input | 3 | Line operand of the command |
| irq_out | output | 1 | Interrupt output, registered |
| win_line | output | 3 | Winning line, registered |
| req_pend | output | 8 | Request bits |
| in_svc | output | 8 | In-service bits |
| prio_base | output | 3 | Rotating priority base |

## Verification
The hardest situation to reach from the ports is two lines in service at once with a third pending between them. Reaching it needs an acknowledge of a low-priority line, then a higher line raised and acknowledged while the first is still in service. The bench builds these nested sets in level mode, where request bits track the input directly. It then applies each service command and checks which bit goes and where the base lands. The special-mode cases use the same nesting, adding a mask write or the cascade line.

// File: rtl/prio_arb_pkg.sv
package prio_arb_pkg;
  typedef enum logic [2:0] {
    OP_NOP        = 3'd0,
    OP_EOI_BEST   = 3'd1,
    OP_EOI_BEST_R = 3'd2,
    OP_EOI_LINE   = 3'd3,
    OP_ROT_LINE   = 3'd4,
    OP_SET_BASE   = 3'd5
  } arb_op_e;
endpackage

// File: rtl/prio_pick.sv
// Finds the best (lowest) priority level in a vector relative to a base.
// N must be a power of two so that index arithmetic wraps modulo N.
module prio_pick #(
  parameter int N  = 8,
  parameter int IW = $clog2(N)
) (
  input  logic [N-1:0]  vec,
  input  logic [IW-1:0] base,
  output logic [IW:0]   lvl,
  output logic [IW-1:0] line
);
  always_comb begin
    logic [IW-1:0] idx;
    lvl  = (IW+1)'(N);
    line = '0;
    for (int k = N-1; k >= 0; k--) begin
      idx = base + IW'(k);
      if (vec[idx]) begin
        lvl  = (IW+1)'(k);
        line = idx;
      end
    end
  end
endmodule

// File: rtl/req_latch.sv
// One request bit with edge or level capture.
module req_latch (
  input  logic clk,
  input  logic rst,
  input  logic req,
  input  logic lvl_mode,
  input  logic clr,
  output logic pend_d,
  output logic pend_q
);
  logic last_q;
  logic rise;

  assign rise = req && !last_q;

  always_comb begin
    if (lvl_mode) pend_d = req;
    else          pend_d = rise || (pend_q && !clr);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      last_q <= 1'b0;
      pend_q <= 1'b0;
    end else begin
      last_q <= req;
      pend_q <= pend_d;
    end
  end

  // R4: an edge-mode bit never turns on without a rising input
  p_edge_only_r4: assert property (@(posedge clk) disable iff (rst)
    (!lvl_mode && !rise && !pend_q) |=> !pend_q);

  // R5: a level-mode bit equals the input sampled at the previous edge
  p_lvl_follow_r5: assert property (@(posedge clk) disable iff (rst)
    lvl_mode |=> (pend_q == $past(req)));
endmodule

// File: rtl/prio_irq_arbiter.sv
module prio_irq_arbiter
  import prio_arb_pkg::*;
#(
  parameter int N_LINES   = 8,
  parameter int CASC_LINE = 2,
  parameter bit IS_MASTER = 1'b1,
  localparam int IW       = $clog2(N_LINES)
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [N_LINES-1:0] req_in,
  input  logic [N_LINES-1:0] trig_level,
  input  logic               mask_we,
  input  logic [N_LINES-1:0] mask_wdata,
  input  logic               sm_en,
  input  logic               sfn_en,
  input  logic               ack,
  input  logic [2:0]         op_code,
  input  logic [IW-1:0]      op_line,
  output logic               irq_out,
  output logic [IW-1:0]      win_line,
  output logic [N_LINES-1:0] req_pend,
  output logic [N_LINES-1:0] in_svc,
  output logic [IW-1:0]      prio_base
);
  localparam logic [N_LINES-1:0] CASC_BIT = N_LINES'(1) << CASC_LINE;

  arb_op_e            op;
  logic [N_LINES-1:0] irr_d, irr_q;
  logic [N_LINES-1:0] isr_d, isr_q;
  logic [N_LINES-1:0] mask_d, mask_q;
  logic [IW-1:0]      base_d, base_q;
  logic               irq_d, irq_q;
  logic [IW-1:0]      win_d, win_q;
  logic               ack_hit;
  logic [IW:0]        eoi_lvl, pend_lvl, svc_lvl;
  logic [IW-1:0]      eoi_line, pend_line, svc_line;
  logic [N_LINES-1:0] pend_vec, svc_vec;

  assign op      = arb_op_e'(op_code);
  assign ack_hit = ack && irq_q;

  // Request capture, one latch per line
  for (genvar g = 0; g < N_LINES; g++) begin : g_req
    req_latch u_lat (
      .clk      (clk),
      .rst      (rst),
      .req      (req_in[g]),
      .lvl_mode (trig_level[g]),
      .clr      (ack_hit && (win_q == IW'(g))),
      .pend_d   (irr_d[g]),
      .pend_q   (irr_q[g])
    );
  end

  // Best in-service line for non-specific end of service (current state)
  prio_pick #(.N(N_LINES)) u_eoi_pick (
    .vec(isr_q), .base(base_q), .lvl(eoi_lvl), .line(eoi_line));

  // In-service and base next state
  always_comb begin
    isr_d  = isr_q;
    base_d = base_q;
    unique case (op)
      OP_EOI_BEST, OP_EOI_BEST_R: begin
        if (eoi_lvl != (IW+1)'(N_LINES)) begin
          isr_d[eoi_line] = 1'b0;
          if (op == OP_EOI_BEST_R) base_d = eoi_line + 1'b1;
        end
      end
      OP_EOI_LINE: isr_d[op_line] = 1'b0;
      OP_ROT_LINE: begin
        isr_d[op_line] = 1'b0;
        base_d         = op_line + 1'b1;
      end
      OP_SET_BASE: base_d = op_line + 1'b1;
      default: ;
    endcase
    if (ack_hit) isr_d[win_q] = 1'b1;
  end

  assign mask_d = mask_we ? mask_wdata : mask_q;

  // Decision on next-state values, so outputs align with state
  assign pend_vec = irr_d & ~mask_d;
  always_comb begin
    svc_vec = isr_d;
    if (sm_en) svc_vec = svc_vec & ~mask_d;
    if (IS_MASTER && sfn_en) svc_vec = svc_vec & ~CASC_BIT;
  end

  prio_pick #(.N(N_LINES)) u_pend_pick (
    .vec(pend_vec), .base(base_d), .lvl(pend_lvl), .line(pend_line));
  prio_pick #(.N(N_LINES)) u_svc_pick (
    .vec(svc_vec), .base(base_d), .lvl(svc_lvl), .line(svc_line));

  assign irq_d = (pend_lvl < svc_lvl);
  assign win_d = (pend_lvl != (IW+1)'(N_LINES)) ? pend_line : '0;

  always_ff @(posedge clk) begin
    if (rst) begin
      isr_q  <= '0;
      mask_q <= '0;
      base_q <= '0;
      irq_q  <= 1'b0;
      win_q  <= '0;
    end else begin
      isr_q  <= isr_d;
      mask_q <= mask_d;
      base_q <= base_d;
      irq_q  <= irq_d;
      win_q  <= win_d;
    end
  end

  assign irq_out   = irq_q;
  assign win_line  = win_q;
  assign req_pend  = irr_q;
  assign in_svc    = isr_q;
  assign prio_base = base_q;

  // R1: reset clears the whole state
  p_reset_clear_r1: assert property (@(posedge clk)
    rst |=> (isr_q == '0 && mask_q == '0 && base_q == '0 && !irq_q));

  // R2: a raised output always names a pending, unmasked line
  p_win_pending_r2: assert property (@(posedge clk) disable iff (rst)
    irq_q |-> (irr_q[win_q] && !mask_q[win_q]));

  // R4: acknowledge moves the winner into service
  p_ack_sets_isr_r4: assert property (@(posedge clk) disable iff (rst)
    (ack && irq_q && op == OP_NOP) |=> isr_q[$past(win_q)]);

  // R8: end of service with nothing in service changes nothing
  p_eoi_empty_r8: assert property (@(posedge clk) disable iff (rst)
    ((op == OP_EOI_BEST || op == OP_EOI_BEST_R) && isr_q == '0 && !ack)
      |=> (isr_q == '0 && $stable(base_q)));

  // R9: set-base places the base one past the operand
  p_set_base_r9: assert property (@(posedge clk) disable iff (rst)
    (op == OP_SET_BASE) |=> ((base_q - 1'b1) == $past(op_line)));
endmodule

// File: tb/sim_prio_irq_arbiter.sv
module sim_prio_irq_arbiter;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [7:0] req_in = '0, trig_level = '0, mask_wdata = '0;
  logic       mask_we = 1'b0, sm_en = 1'b0, sfn_en = 1'b0, ack = 1'b0;
  logic [2:0] op_code = '0, op_line = '0;
  logic       irq_out;
  logic [2:0] win_line, prio_base;
  logic [7:0] req_pend, in_svc;

  int nchk = 0;
  int nerr = 0;

  always #4 clk = ~clk;

  prio_irq_arbiter u0 (
    .clk(clk), .rst(rst), .req_in(req_in), .trig_level(trig_level),
    .mask_we(mask_we), .mask_wdata(mask_wdata), .sm_en(sm_en),
    .sfn_en(sfn_en), .ack(ack), .op_code(op_code), .op_line(op_line),
    .irq_out(irq_out), .win_line(win_line), .req_pend(req_pend),
    .in_svc(in_svc), .prio_base(prio_base));

  task automatic chk(input string tag, input int act, input int exp);
    nchk++;
    if (act != exp) begin
      nerr++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic step();
    @(negedge clk);
  endtask

  task automatic do_reset();
    rst = 1'b1; req_in = '0; trig_level = '0; mask_we = 1'b0;
    mask_wdata = '0; sm_en = 1'b0; sfn_en = 1'b0; ack = 1'b0;
    op_code = '0; op_line = '0;
    step();
    rst = 1'b0;
  endtask

  task automatic pulse_ack();
    ack = 1'b1; step(); ack = 1'b0;
  endtask

  task automatic pulse_op(input logic [2:0] c, input logic [2:0] l);
    op_code = c; op_line = l; step(); op_code = 3'd0;
  endtask

  function automatic int best_line(input logic [7:0] v, input int b);
    for (int lv = 0; lv < 8; lv++)
      if (v[(lv + b) % 8]) return (lv + b) % 8;
    return 0;
  endfunction

  task automatic finish_up();
    $display("Result: errors=%0d of %0d checks", nerr, nchk);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    nerr++;
    $display("FAIL watchdog expired");
    finish_up();
  end

  initial begin
    step();
    do_reset();
    step();
    // R1: reset state
    chk("R1 irq", irq_out, 0);
    chk("R1 irr", req_pend, 0);
    chk("R1 isr", in_svc, 0);
    chk("R1 base", prio_base, 0);

    // R2: sweep every base and every request pattern (level mode)
    trig_level = 8'hFF;
    for (int b = 0; b < 8; b++) begin
      pulse_op(3'd5, 3'((b + 7) % 8));
      chk("R9 set base", prio_base, b);
      for (int p = 0; p < 256; p++) begin
        req_in = 8'(p);
        step();
        chk("R2 irq", irq_out, (p != 0) ? 1 : 0);
        chk("R2 win", win_line, best_line(8'(p), b));
      end
    end

    // R3: one line in service, one other pending, base 0
    for (int s = 0; s < 8; s++)
      for (int p = 0; p < 8; p++) begin
        do_reset();
        trig_level = 8'hFF;
        req_in = 8'(1 << s);
        step();
        pulse_ack();
        req_in = 8'((1 << s) | (1 << p));
        step();
        chk("R3 strict compare", irq_out, (p < s) ? 1 : 0);
      end

    // R4: edge capture and acknowledge
    do_reset();
    req_in = 8'h40;
    step();
    chk("R4 edge set", req_pend, 8'h40);
    chk("R4 win", win_line, 6);
    pulse_ack();
    chk("R4 ack isr", in_svc, 8'h40);
    chk("R4 ack clears edge", req_pend, 0);
    step();
    chk("R4 held high no reset", req_pend, 0);
    req_in = 8'h00; step();
    req_in = 8'h40; step();
    chk("R4 new edge", req_pend, 8'h40);

    // R5: level capture survives acknowledge
    do_reset();
    trig_level = 8'h02;
    req_in = 8'h02; step();
    chk("R5 level set", req_pend, 8'h02);
    pulse_ack();
    chk("R5 isr", in_svc, 8'h02);
    chk("R5 ack keeps level", req_pend, 8'h02);
    req_in = 8'h00; step();
    chk("R5 level drop", req_pend, 0);

    // R6: special mask mode
    do_reset();
    trig_level = 8'hFF;
    req_in = 8'h08; step();
    pulse_ack();
    req_in = 8'h28; step();
    chk("R6 blocked by isr", irq_out, 0);
    mask_we = 1'b1; mask_wdata = 8'h08; step(); mask_we = 1'b0;
    chk("R6 no special mask", irq_out, 0);
    sm_en = 1'b1; step();
    chk("R6 special mask irq", irq_out, 1);
    chk("R6 special mask win", win_line, 5);

    // R7: special fully nested on cascade line
    do_reset();
    trig_level = 8'hFF;
    sfn_en = 1'b1;
    req_in = 8'h04; step();
    pulse_ack();
    chk("R7 isr", in_svc, 8'h04);
    chk("R7 nested irq", irq_out, 1);
    chk("R7 nested win", win_line, 2);
    sfn_en = 1'b0; step();
    chk("R7 off blocks", irq_out, 0);
    sfn_en = 1'b1; req_in = 8'h14; step();
    chk("R7 on again", irq_out, 1);

    // R8: non-specific end of service
    do_reset();
    trig_level = 8'hFF;
    req_in = 8'h20; step();
    pulse_ack();
    req_in = 8'h28; step();
    chk("R8 win 3", win_line, 3);
    pulse_ack();
    chk("R8 nested isr", in_svc, 8'h28);
    req_in = 8'h00;
    pulse_op(3'd1, 3'd0);
    chk("R8 eoi best", in_svc, 8'h20);
    chk("R8 eoi base", prio_base, 0);
    pulse_op(3'd2, 3'd0);
    chk("R8 eoi rot isr", in_svc, 0);
    chk("R8 eoi rot base", prio_base, 6);
    pulse_op(3'd1, 3'd0);
    chk("R8 empty isr", in_svc, 0);
    chk("R8 empty base", prio_base, 6);

    // R9: specific commands
    do_reset();
    trig_level = 8'hFF;
    req_in = 8'h10; step();
    pulse_ack();
    req_in = 8'h12; step();
    pulse_ack();
    req_in = 8'h00;
    chk("R9 isr", in_svc, 8'h12);
    pulse_op(3'd5, 3'd5);
    chk("R9 set base", prio_base, 6);
    chk("R9 set keeps isr", in_svc, 8'h12);
    pulse_op(3'd3, 3'd4);
    chk("R9 eoi line", in_svc, 8'h02);
    pulse_op(3'd4, 3'd1);
    chk("R9 rot line isr", in_svc, 0);
    chk("R9 rot line base", prio_base, 2);
    pulse_op(3'd0, 3'd6);
    chk("R9 nop base", prio_base, 2);

    // R10: mask write
    do_reset();
    trig_level = 8'hFF;
    req_in = 8'h01; mask_we = 1'b1; mask_wdata = 8'h01; step();
    chk("R10 masked irq", irq_out, 0);
    chk("R10 masked irr", req_pend, 8'h01);
    mask_wdata = 8'h00; step(); mask_we = 1'b0;
    chk("R10 unmasked irq", irq_out, 1);
    chk("R10 unmasked win", win_line, 0);

    // R11: acknowledge with output low
    do_reset();
    step();
    pulse_ack();
    chk("R11 isr", in_svc, 0);
    chk("R11 irq", irq_out, 0);

    finish_up();
  end
endmodule